// File: doc/BRIEF.md
# Source-Synchronous Clock Group Tracker

This block decides when a group of source-synchronous capture clocks has finished, and it controls the reset of the small valid FIFO that qualifies the group. Edge detectors upstream send one single-cycle strobe per clock input. These strobes arrive in the system clock domain. An enable mask picks which inputs take part. One configured input is the completing clock. The other enabled inputs are preceding events. Each cycle that holds preceding events pushes their mask into a four-entry valid FIFO. When the completing clock fires, the block emits a one-cycle group-valid pulse. The pulse reports how many event entries are held and which mask came first.

Two reset schemes exist, and only one is active at a time. In counter mode, an 8-bit watchdog counts every system cycle and starts from a programmable preset. Clock activity reloads it: either any enabled strobe, or a master heartbeat edge when that source is chosen. When it wraps past its maximum, it fires a one-cycle FIFO reset and reloads itself. In external mode, one clock input is handed over to act as a level-sensitive reset line with selectable polarity. That input is then removed from the event set.

Configuration is loaded only while acquisition is stopped. Every accepted load flushes the FIFO and the counter.

Top module: `ssclk_group_tracker`

## Requirements
- R1: After reset, all outputs are 0. The configuration is counter mode, preset 0, strobe reload source, completing clock index 3, external polarity active-high.
- R2: While `run` is high, an enabled strobe on the completing index raises `grp_valid` for exactly one cycle, one cycle later.
- R3: `grp_depth` and `grp_head` give the FIFO count and oldest mask in the `grp_valid` cycle, and are 0 in every other cycle. Completion empties the FIFO. Preceding strobes in the same cycle as the completing strobe are dropped.
- R4: Each cycle with at least one enabled non-completing strobe pushes one entry (bit i = input i). Once four entries are held, further pushes are dropped.
- R5: In counter mode with preset P, `fifo_rst` is high for one cycle exactly 256-P cycles after the cycle in which the counter was loaded. The counter then reloads P and repeats. Each pulse empties the FIFO.
- R6: In counter mode, with the strobe reload source, any enabled strobe reloads the preset. Disabled strobes have no effect.
- R7: A reload in the cycle that would wrap cancels that reset pulse. A push in the same cycle as a FIFO reset is kept as the first entry.
- R8: With the heartbeat source selected, only `hb_edge` reloads the counter, and strobes do not.
- R9: In external mode (`cfg_mode` = 2'b10), `fifo_rst` follows `ext_rst_in == cfg_ext_pol` one cycle later. The counter does not act, and strobes on `cfg_ext_idx` are ignored.
- R10: `cfg_mode` is 2'b01 for counter mode or 2'b10 for external mode. A write carrying any other code is rejected entirely.
- R11: `cfg_we` is accepted only while `run` is low. An accepted write empties the FIFO and reloads the counter.
- R12: While `run` is low, strobes are ignored, the counter holds its preset, and both pulse outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Acquisition active |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_mode | input | 2 | 01 counter mode, 10 external mode |
| cfg_preset | input | 8 | Counter preset |
| cfg_hb_sel | input | 1 | 1: heartbeat reloads the counter |
| cfg_ext_idx | input | 2 | Input handed over as external reset |
| cfg_ext_pol | input | 1 | Active level of the external reset |
| cfg_done_idx | input | 2 | Index of the completing clock |
| strobe | input | 4 | Per-input edge strobes |
| strobe_en | input | 4 | Enable mask |
| hb_edge | input | 1 | Master heartbeat edge strobe |
| ext_rst_in | input | 1 | External reset level |
| grp_valid | output | 1 | Group complete pulse |
| grp_depth | output | 3 | Entries held at completion |
| grp_head | output | 4 | Oldest entry mask at completion |
| fifo_rst | output | 1 | Valid FIFO reset |

## Verification
All four outputs are registered, so every result is due exactly one cycle after the edge that samples its cause. The only exception is the watchdog wrap, which is due 256-P cycles after the loading edge. The bench drives inputs on the falling edge and keeps a cycle counter. For each stimulus it queues expected output values tagged with the absolute cycle in which they are due, including the quiet cycles around each pulse. A monitor compares all outputs at the falling edge of exactly that cycle. A pulse that comes one cycle early or late therefore fails in two places.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
  localparam int SGT_NCLK  = 4;
  localparam int SGT_DEPTH = 4;
  localparam int SGT_CW    = 8;
  localparam int SGT_IW    = $clog2(SGT_NCLK);

  typedef enum logic [1:0] {
    MODE_CNT = 2'b01,
    MODE_EXT = 2'b10
  } mode_e;

  typedef struct packed {
    mode_e              mode;
    logic [SGT_CW-1:0]  preset;
    logic               hb_sel;
    logic [SGT_IW-1:0]  ext_idx;
    logic               ext_pol;
    logic [SGT_IW-1:0]  done_idx;
  } cfg_t;
endpackage

// File: rtl/sgt_cfg.sv
module sgt_cfg import sgt_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              we,
  input  logic [1:0]        mode_i,
  input  logic [SGT_CW-1:0] preset_i,
  input  logic              hb_i,
  input  logic [SGT_IW-1:0] ext_idx_i,
  input  logic              ext_pol_i,
  input  logic [SGT_IW-1:0] done_idx_i,
  output cfg_t              cfg_o,
  output logic [SGT_CW-1:0] preset_ld_o,
  output logic              clr_o
);
  cfg_t cfg_q, cfg_in;
  logic legal, accept;

  always_comb begin
    cfg_in.mode     = mode_e'(mode_i);
    cfg_in.preset   = preset_i;
    cfg_in.hb_sel   = hb_i;
    cfg_in.ext_idx  = ext_idx_i;
    cfg_in.ext_pol  = ext_pol_i;
    cfg_in.done_idx = done_idx_i;
  end

  assign legal  = (mode_i == MODE_CNT) || (mode_i == MODE_EXT);
  assign accept = we && !run && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{mode: MODE_CNT, preset: '0, hb_sel: 1'b0, ext_idx: '0,
                 ext_pol: 1'b1, done_idx: SGT_IW'(SGT_NCLK - 1)};
    end else if (accept) begin
      cfg_q <= cfg_in;
    end
  end

  assign cfg_o       = cfg_q;
  assign clr_o       = accept;
  assign preset_ld_o = accept ? preset_i : cfg_q.preset;

  p_mode_legal_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == MODE_CNT) || (cfg_q.mode == MODE_EXT));

  p_locked_run_r11: assert property (@(posedge clk) disable iff (rst)
    (we && run) |=> $stable(cfg_q));
endmodule

// File: rtl/sgt_wdog.sv
module sgt_wdog #(
  parameter int CW = 8,
  localparam logic [CW-1:0] MAXV = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          clr,
  input  logic          reload,
  input  logic [CW-1:0] preset,
  input  logic [CW-1:0] preset_ld,
  output logic          ovf
);
  logic [CW-1:0] cnt;

  assign ovf = active && !clr && !reload && (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (!active || clr)    cnt <= preset_ld;
    else if (reload || cnt == MAXV) cnt <= preset;
    else                        cnt <= cnt + 1'b1;
  end

  p_single_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf && preset != MAXV) |=> !ovf);

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (active && !clr && reload) |=> (cnt == $past(preset)));
endmodule

// File: rtl/sgt_vfifo.sv
module sgt_vfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic [DW-1:0] count,
  output logic [W-1:0]  head
);
  logic [W-1:0]  mem [DEPTH];
  logic          can_push;
  logic [AW-1:0] widx;

  assign can_push = push && (clr || count < DW'(DEPTH));
  assign widx     = clr ? '0 : count[AW-1:0];

  always_ff @(posedge clk) begin
    if (can_push) mem[widx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (clr)      count <= push ? DW'(1) : '0;
    else if (can_push) count <= count + 1'b1;
  end

  assign head = (count != '0) ? mem[0] : '0;

  p_cap_r4: assert property (@(posedge clk) disable iff (rst)
    count <= DW'(DEPTH));

  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !clr && count == DW'(DEPTH)) |=> (count == DW'(DEPTH)));

  p_flush_r3: assert property (@(posedge clk) disable iff (rst)
    (clr && !push) |=> (count == '0));
endmodule

// File: rtl/ssclk_group_tracker.sv
module ssclk_group_tracker import sgt_pkg::*; #(
  parameter int DEPTH = SGT_DEPTH,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_mode,
  input  logic [SGT_CW-1:0]   cfg_preset,
  input  logic                cfg_hb_sel,
  input  logic [SGT_IW-1:0]   cfg_ext_idx,
  input  logic                cfg_ext_pol,
  input  logic [SGT_IW-1:0]   cfg_done_idx,
  input  logic [SGT_NCLK-1:0] strobe,
  input  logic [SGT_NCLK-1:0] strobe_en,
  input  logic                hb_edge,
  input  logic                ext_rst_in,
  output logic                grp_valid,
  output logic [DW-1:0]       grp_depth,
  output logic [SGT_NCLK-1:0] grp_head,
  output logic                fifo_rst
);
  cfg_t              cfg;
  logic [SGT_CW-1:0] preset_ld;
  logic              cfg_clr;

  sgt_cfg u_cfg (
    .clk(clk), .rst(rst), .run(run), .we(cfg_we),
    .mode_i(cfg_mode), .preset_i(cfg_preset), .hb_i(cfg_hb_sel),
    .ext_idx_i(cfg_ext_idx), .ext_pol_i(cfg_ext_pol), .done_idx_i(cfg_done_idx),
    .cfg_o(cfg), .preset_ld_o(preset_ld), .clr_o(cfg_clr)
  );

  logic                ext_mode, cnt_mode;
  logic [SGT_NCLK-1:0] ev, done_oh, others;
  logic                done_hit, push, reload, ext_act, ovf, fclr;
  logic [DW-1:0]       f_count;
  logic [SGT_NCLK-1:0] f_head;

  assign ext_mode = (cfg.mode == MODE_EXT);
  assign cnt_mode = (cfg.mode == MODE_CNT);

  for (genvar i = 0; i < SGT_NCLK; i++) begin : g_lane
    assign done_oh[i] = (cfg.done_idx == SGT_IW'(i));
    assign ev[i]      = strobe[i] & strobe_en[i] &
                        ~(ext_mode && (cfg.ext_idx == SGT_IW'(i)));
  end

  assign others   = ev & ~done_oh;
  assign done_hit = run && |(ev & done_oh);
  assign push     = run && |others && !done_hit;
  assign reload   = cfg.hb_sel ? hb_edge : |ev;
  assign ext_act  = run && ext_mode && (ext_rst_in == cfg.ext_pol);

  sgt_wdog #(.CW(SGT_CW)) u_wdog (
    .clk(clk), .rst(rst), .active(run && cnt_mode), .clr(cfg_clr),
    .reload(reload), .preset(cfg.preset), .preset_ld(preset_ld), .ovf(ovf)
  );

  assign fclr = cfg_clr | ovf | ext_act | done_hit;

  sgt_vfifo #(.DEPTH(DEPTH), .W(SGT_NCLK)) u_fifo (
    .clk(clk), .rst(rst), .clr(fclr), .push(push), .din(others),
    .count(f_count), .head(f_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_valid <= 1'b0;
      grp_depth <= '0;
      grp_head  <= '0;
      fifo_rst  <= 1'b0;
    end else begin
      grp_valid <= done_hit;
      grp_depth <= done_hit ? f_count : '0;
      grp_head  <= done_hit ? f_head  : '0;
      fifo_rst  <= ovf | ext_act;
    end
  end

  p_ext_level_r9: assert property (@(posedge clk) disable iff (rst)
    (run && ext_mode && ext_rst_in == cfg.ext_pol) |=> fifo_rst);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!grp_valid && !fifo_rst));

  p_report_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !grp_valid |-> (grp_depth == '0 && grp_head == '0));

  p_valid_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> $past(run));
endmodule

// File: tb/ssclk_group_tracker_test.sv
module ssclk_group_tracker_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b01;
  logic [7:0] cfg_preset = 8'd0;
  logic       cfg_hb_sel = 1'b0;
  logic [1:0] cfg_ext_idx = 2'd0;
  logic       cfg_ext_pol = 1'b1;
  logic [1:0] cfg_done_idx = 2'd3;
  logic [3:0] strobe = 4'b0;
  logic [3:0] strobe_en = 4'b1111;
  logic       hb_edge = 1'b0;
  logic       ext_rst_in = 1'b0;
  logic       grp_valid;
  logic [2:0] grp_depth;
  logic [3:0] grp_head;
  logic       fifo_rst;

  ssclk_group_tracker uut (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_preset(cfg_preset), .cfg_hb_sel(cfg_hb_sel), .cfg_ext_idx(cfg_ext_idx),
    .cfg_ext_pol(cfg_ext_pol), .cfg_done_idx(cfg_done_idx), .strobe(strobe),
    .strobe_en(strobe_en), .hb_edge(hb_edge), .ext_rst_in(ext_rst_in),
    .grp_valid(grp_valid), .grp_depth(grp_depth), .grp_head(grp_head),
    .fifo_rst(fifo_rst)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         cyc;
    logic       v;
    logic [2:0] d;
    logic [3:0] h;
    logic       f;
    string      r;
  } exp_t;

  exp_t sb[$];
  exp_t me;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   fin = 1'b0;

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      me = sb.pop_front();
      n_vec++;
      if (me.cyc != cyc || grp_valid !== me.v || grp_depth !== me.d ||
          grp_head !== me.h || fifo_rst !== me.f) begin
        n_bad++;
        $display("FAIL %s cyc %0d (due %0d): got v=%0b d=%0d h=%b f=%0b, expected v=%0b d=%0d h=%b f=%0b",
                 me.r, cyc, me.cyc, grp_valid, grp_depth, grp_head, fifo_rst,
                 me.v, me.d, me.h, me.f);
      end
    end
  end

  task automatic exp_one(int c, bit v, int d, int h, bit f, string r);
    exp_t e;
    e.cyc = c; e.v = v; e.d = 3'(d); e.h = 4'(h); e.f = f; e.r = r;
    sb.push_back(e);
  endtask

  task automatic exp_quiet(int a, int b, string r);
    for (int c = a; c <= b; c++) exp_one(c, 0, 0, 0, 0, r);
  endtask

  task automatic go_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic put(logic [3:0] s);
    strobe = s;
    @(negedge clk);
    strobe = 4'b0;
  endtask

  task automatic start_run(logic [3:0] s);
    run = 1'b1;
    put(s);
  endtask

  // R12: idle cycles with a completing strobe present produce nothing
  task automatic idle(int n);
    int c;
    c = cyc;
    exp_quiet(c + 1, c + n, "R12");
    run = 1'b0;
    strobe = 4'b1000;
    repeat (n) @(negedge clk);
    strobe = 4'b0;
  endtask

  task automatic cfg_write(logic [1:0] m, logic [7:0] p, logic hb, logic [1:0] ei,
                           logic pol, logic [1:0] di);
    cfg_mode = m; cfg_preset = p; cfg_hb_sel = hb;
    cfg_ext_idx = ei; cfg_ext_pol = pol; cfg_done_idx = di;
    cfg_we = 1'b1;
    exp_quiet(cyc + 1, cyc + 1, "R11");
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t = cyc;
    exp_quiet(t + 1, t + 3, "R1");
    go_to(t + 3);

    // R1: default config - completing index 3, preset 0 -> wrap 256 after load
    t = cyc;
    exp_one(t + 1, 1, 0, 0, 0, "R1");
    exp_quiet(t + 2, t + 256, "R1");
    exp_one(t + 257, 0, 0, 0, 1, "R1");
    start_run(4'b1000);
    go_to(t + 257);
    idle(3);

    cfg_write(2'b01, 8'd250, 1'b0, 2'd2, 1'b0, 2'd3);

    // R5/R6: load at t+1, wrap every 6 cycles; FIFO emptied by the wrap
    t = cyc;
    exp_quiet(t + 1, t + 6, "R5");
    exp_one(t + 7, 0, 0, 0, 1, "R5");
    exp_quiet(t + 8, t + 12, "R5");
    exp_one(t + 13, 0, 0, 0, 1, "R5");
    exp_one(t + 14, 1, 0, 0, 0, "R5");
    // R7: reload in the wrap cycle cancels it
    exp_quiet(t + 15, t + 25, "R7");
    exp_one(t + 26, 0, 0, 0, 1, "R7");
    start_run(4'b0001);
    go_to(t + 13);
    put(4'b1000);
    go_to(t + 19);
    put(4'b0001);
    go_to(t + 26);
    idle(3);

    // R2/R3: completion report, then same-cycle preceding strobes dropped
    t = cyc;
    exp_quiet(t + 1, t + 2, "R2");
    exp_one(t + 3, 1, 2, 4'b0001, 0, "R2");
    exp_quiet(t + 4, t + 4, "R2");
    exp_one(t + 5, 1, 0, 0, 0, "R3");
    exp_quiet(t + 6, t + 10, "R3");
    exp_one(t + 11, 0, 0, 0, 1, "R5");
    start_run(4'b0001);
    put(4'b0110);
    put(4'b1000);
    @(negedge clk);
    put(4'b1011);
    go_to(t + 11);
    idle(3);

    // R4: five pushes, four kept, head is the first
    t = cyc;
    exp_quiet(t + 1, t + 5, "R4");
    exp_one(t + 6, 1, 4, 4'b0010, 0, "R4");
    exp_quiet(t + 7, t + 11, "R4");
    exp_one(t + 12, 0, 0, 0, 1, "R5");
    start_run(4'b0010);
    put(4'b0100);
    put(4'b0001);
    put(4'b0010);
    put(4'b0100);
    put(4'b1000);
    go_to(t + 12);
    idle(3);

    // R6: disabled strobes neither reload nor complete
    t = cyc;
    exp_quiet(t + 1, t + 6, "R6");
    exp_one(t + 7, 0, 0, 0, 1, "R6");
    start_run(4'b0001);
    go_to(t + 4);
    strobe_en = 4'b0110;
    put(4'b1001);
    strobe_en = 4'b1111;
    go_to(t + 7);
    idle(3);

    // R8: heartbeat reload source; R7: push during a wrap is kept
    cfg_write(2'b01, 8'd250, 1'b1, 2'd2, 1'b0, 2'd3);
    t = cyc;
    exp_quiet(t + 1, t + 6, "R8");
    exp_one(t + 7, 0, 0, 0, 1, "R8");
    exp_quiet(t + 8, t + 8, "R8");
    exp_one(t + 9, 1, 1, 4'b0001, 0, "R7");
    exp_quiet(t + 10, t + 18, "R8");
    exp_one(t + 19, 0, 0, 0, 1, "R8");
    hb_edge = 1'b1;
    start_run(4'b0001);
    hb_edge = 1'b0;
    go_to(t + 3);
    put(4'b0001);
    go_to(t + 6);
    put(4'b0001);
    go_to(t + 8);
    put(4'b1000);
    go_to(t + 12);
    hb_edge = 1'b1;
    @(negedge clk);
    hb_edge = 1'b0;
    go_to(t + 19);
    idle(3);

    // R9: external level reset, active-low, input 2 handed over
    cfg_write(2'b10, 8'd250, 1'b0, 2'd2, 1'b0, 2'd3);
    t = cyc;
    ext_rst_in = 1'b1;
    exp_quiet(t + 1, t + 20, "R9");
    exp_one(t + 21, 0, 0, 0, 1, "R9");
    exp_one(t + 22, 0, 0, 0, 1, "R9");
    exp_one(t + 23, 0, 0, 0, 1, "R9");
    exp_quiet(t + 24, t + 27, "R9");
    exp_one(t + 28, 1, 1, 4'b0010, 0, "R9");
    exp_quiet(t + 29, t + 30, "R9");
    start_run(4'b0000);
    go_to(t + 20);
    ext_rst_in = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst_in = 1'b1;
    go_to(t + 25);
    put(4'b0100);
    put(4'b0010);
    put(4'b1000);
    go_to(t + 30);
    idle(3);

    // R10: illegal mode code rejected, external mode stays in force
    cfg_write(2'b11, 8'd100, 1'b0, 2'd2, 1'b0, 2'd3);
    t = cyc;
    exp_one(t + 1, 0, 0, 0, 1, "R10");
    exp_one(t + 2, 0, 0, 0, 1, "R10");
    exp_quiet(t + 3, t + 10, "R10");
    ext_rst_in = 1'b0;
    start_run(4'b0000);
    go_to(t + 2);
    ext_rst_in = 1'b1;
    go_to(t + 10);
    idle(3);

    // R11: write during run ignored (preset stays 250)
    cfg_write(2'b01, 8'd250, 1'b0, 2'd2, 1'b0, 2'd3);
    t = cyc;
    exp_quiet(t + 1, t + 6, "R11");
    exp_one(t + 7, 0, 0, 0, 1, "R11");
    exp_quiet(t + 8, t + 12, "R11");
    exp_one(t + 13, 0, 0, 0, 1, "R11");
    exp_quiet(t + 14, t + 14, "R11");
    start_run(4'b0001);
    go_to(t + 2);
    cfg_preset = 8'd200;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    go_to(t + 13);
    put(4'b0010);
    idle(2);
    // R11: accepted write empties the FIFO that held one entry
    cfg_write(2'b01, 8'd250, 1'b0, 2'd2, 1'b0, 2'd3);
    t = cyc;
    exp_one(t + 1, 1, 0, 0, 0, "R11");
    exp_quiet(t + 2, t + 3, "R11");
    start_run(4'b1000);
    go_to(t + 3);
    run = 1'b0;
    repeat (2) @(negedge clk);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule